// File: doc/BRIEF.md
# I2C Master Status and Interrupt Register Block

This block holds the control and status side of a register-mapped I2C master. It does not hold the data path. A byte-wide register port reaches an 18-byte window of registers: mode control, status, extended status, interrupt mask, transfer count, a soft-reset trigger, a direct line-control register, two address registers and a clock divider. The bus sequencer reports two kinds of event to the block: a transfer finished (with the number of bytes moved) and a transfer halted. The block turns those events into one level interrupt line, gated by a global enable and a mask bit for each event.

Software takes an interrupt down by writing a one to the pending bit of the status register. Only selected status bits respond to such writes. The extended status register does not store the bus state: a read returns the state live from the bus-busy input. Writing one bit of the soft-reset register returns every register to its default, except the two address registers, which keep their contents.

Register offsets: 0 mode, 1 status, 2 extended status, 3 interrupt mask, 4 transfer count, 5 soft reset, 6 direct control, 7 address low, 8 address high, 9 clock divider. Offsets 10 to 17 are reserved. Reads return combinationally from `reg_addr`, and writes take effect at the clock edge that samples `reg_wr`.

Top module: `i2c_stat_irq`

## Requirements
- R1: After hardware reset, the following read as 0: mode, status, interrupt mask, transfer count, clock divider and both address registers. Direct control reads 0x0F and `irq` is low.
- R2: A write to mode (offset 0) stores only the bits under 0x3D. Bit 2 of mode is the global interrupt enable.
- R3: A completion event with a nonzero byte count sets status bit 1 and raises `irq` on the next edge, provided mode bit 2 and interrupt-mask bit 0 are both set. A completion with a byte count of zero raises nothing. Every completion event loads its byte count into the transfer count register (offset 4).
- R4: A halt event sets status bit 1 and raises `irq` on the next edge, provided mode bit 2 and interrupt-mask bit 3 are both set.
- R5: An event whose mask bit is clear, or any event while mode bit 2 is clear, leaves status bit 1 and `irq` unchanged.
- R6: A write to status (offset 1) clears only the bits that are written as one and also fall under 0x0A. If that write has bit 1 set while mode bit 2 is set, `irq` falls on the next edge. While mode bit 2 is clear, the same write clears the status bit but `irq` stays high.
- R7: A read of extended status (offset 2) returns 0x50 while `bus_busy` is high and 0x40 while it is low. Writes to this offset change nothing that can be read.
- R8: A write to transfer count keeps only the bits under 0x77.
- R9: A write to offset 5 with bit 0 set returns these registers to their R1 defaults and drops `irq`: mode, status, mask, transfer count, direct control and clock divider. Both address registers keep their values. A write to offset 5 with bit 0 clear changes nothing.
- R10: Offsets 10 to 17, and any offset of 18 or above, read as 0. Writes to them change no register.
- R11: If an enabled event and a status write that clears bit 1 occur in the same cycle, the event wins: `irq` ends high and status bit 1 stays set.
- R12: Direct control (offset 6) stores the low four bits of a write. Its upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| reg_addr | input | AW (5) | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| xfer_done | input | 1 | One-cycle pulse: a transfer completed |
| xfer_bytes | input | CNT_W (3) | Bytes moved by the completed transfer |
| xfer_halt | input | 1 | One-cycle pulse: a transfer was halted |
| bus_busy | input | 1 | Live bus-busy state |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `xfer_done` and `xfer_halt` are single-cycle pulses, that `xfer_bytes` is meaningful only while `xfer_done` is high, and that the register port makes at most one write per cycle. The stimulus drives each event for exactly one clock and holds `xfer_bytes` with it. It applies register writes one at a time. A simultaneous event and status clear is raised on purpose in one place only, to exercise the priority rule.

// File: rtl/i2c_si_pkg.sv
package i2c_si_pkg;

  localparam int DW = 8;

  // register offsets (byte addresses inside the window)
  localparam int OFF_MODE   = 0;
  localparam int OFF_STAT   = 1;
  localparam int OFF_XSTAT  = 2;
  localparam int OFF_IMASK  = 3;
  localparam int OFF_COUNT  = 4;
  localparam int OFF_SRST   = 5;
  localparam int OFF_DIRECT = 6;
  localparam int OFF_ADRLO  = 7;
  localparam int OFF_ADRHI  = 8;
  localparam int OFF_CLKDIV = 9;

  localparam logic [DW-1:0] MODE_WMASK   = 8'h3D;
  localparam logic [DW-1:0] STAT_CLRMASK = 8'h0A;
  localparam logic [DW-1:0] XST_CLRMASK  = 8'h8F;
  localparam logic [DW-1:0] COUNT_WMASK  = 8'h77;
  localparam logic [DW-1:0] DIRECT_WMASK = 8'h0F;
  localparam logic [DW-1:0] DIRECT_RST   = 8'h0F;

  localparam int MODE_GEN_BIT   = 2;
  localparam int STAT_PEND_BIT  = 1;
  localparam int MASK_DONE_BIT  = 0;
  localparam int MASK_HALT_BIT  = 3;
  localparam int SRST_TRIG_BIT  = 0;

  typedef struct packed {
    logic mode;
    logic stat;
    logic xstat;
    logic imask;
    logic count;
    logic srst;
    logic direct;
    logic adrlo;
    logic adrhi;
    logic clkdiv;
  } wstrb_t;

  // write-one-to-clear restricted to a mask
  function automatic logic [DW-1:0] w1c(input logic [DW-1:0] cur,
                                        input logic [DW-1:0] wv,
                                        input logic [DW-1:0] msk);
    return cur & ~(wv & msk);
  endfunction

  // live bus-state code seen at the extended status offset
  function automatic logic [DW-1:0] xstat_code(input logic busy);
    return busy ? 8'h50 : 8'h40;
  endfunction

  // an event fires when global enable and its own mask bit are both set
  function automatic logic gate_evt(input logic evt, input logic gen,
                                    input logic msk);
    return evt & gen & msk;
  endfunction

endpackage

// File: rtl/i2c_si_decode.sv
module i2c_si_decode
  import i2c_si_pkg::*;
#(
  parameter int AW     = 5,
  parameter int WINDOW = 18
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  output wstrb_t        strb,
  output logic          in_window
);

  localparam int NREG = OFF_CLKDIV + 1;

  logic [NREG-1:0] hit;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_hit
      assign hit[g] = (addr == AW'(g));
    end
  endgenerate

  assign in_window = (int'(addr) < WINDOW);

  always_comb begin
    strb        = '0;
    strb.mode   = wr & hit[OFF_MODE];
    strb.stat   = wr & hit[OFF_STAT];
    strb.xstat  = wr & hit[OFF_XSTAT];
    strb.imask  = wr & hit[OFF_IMASK];
    strb.count  = wr & hit[OFF_COUNT];
    strb.srst   = wr & hit[OFF_SRST];
    strb.direct = wr & hit[OFF_DIRECT];
    strb.adrlo  = wr & hit[OFF_ADRLO];
    strb.adrhi  = wr & hit[OFF_ADRHI];
    strb.clkdiv = wr & hit[OFF_CLKDIV];
  end

endmodule

// File: rtl/i2c_si_ctrl.sv
module i2c_si_ctrl
  import i2c_si_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  wstrb_t         strb,
  input  logic [DW-1:0]  wdata,
  input  logic           done_evt,
  input  logic [CNT_W-1:0] done_cnt,
  output logic           soft_rst,
  output logic [DW-1:0]  mode_q,
  output logic [DW-1:0]  imask_q,
  output logic [DW-1:0]  count_q,
  output logic [DW-1:0]  direct_q,
  output logic [DW-1:0]  adrlo_q,
  output logic [DW-1:0]  adrhi_q,
  output logic [DW-1:0]  clkdiv_q
);

  assign soft_rst = strb.srst & wdata[SRST_TRIG_BIT];

  // registers restored by the soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      imask_q  <= '0;
      count_q  <= '0;
      direct_q <= DIRECT_RST;
      clkdiv_q <= '0;
    end else if (soft_rst) begin
      mode_q   <= '0;
      imask_q  <= '0;
      count_q  <= '0;
      direct_q <= DIRECT_RST;
      clkdiv_q <= '0;
    end else begin
      if (strb.mode)   mode_q   <= wdata & MODE_WMASK;
      if (strb.imask)  imask_q  <= wdata;
      if (strb.direct) direct_q <= wdata & DIRECT_WMASK;
      if (strb.clkdiv) clkdiv_q <= wdata;
      if (done_evt)        count_q <= DW'(done_cnt);
      else if (strb.count) count_q <= wdata & COUNT_WMASK;
    end
  end

  // address registers survive the soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adrlo_q <= '0;
      adrhi_q <= '0;
    end else begin
      if (strb.adrlo) adrlo_q <= wdata;
      if (strb.adrhi) adrhi_q <= wdata;
    end
  end

  a_r2_mode_bits: assert property (@(posedge clk) disable iff (!rst_n)
    strb.mode && !soft_rst |=> (mode_q & ~MODE_WMASK) == '0);

  a_r9_srst_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> mode_q == '0 && imask_q == '0 && count_q == '0 &&
                 direct_q == DIRECT_RST && clkdiv_q == '0);

  a_r9_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !strb.adrlo && !strb.adrhi |=>
      $stable(adrlo_q) && $stable(adrhi_q));

  a_r3_count_load: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !soft_rst |=> count_q == DW'($past(done_cnt)));

endmodule

// File: rtl/i2c_si_irq.sv
module i2c_si_irq
  import i2c_si_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_wr,
  input  logic [DW-1:0]    wdata,
  input  logic             soft_rst,
  input  logic             gen_en,
  input  logic [DW-1:0]    imask,
  input  logic             done_evt,
  input  logic [CNT_W-1:0] done_cnt,
  input  logic             halt_evt,
  output logic [DW-1:0]    stat_q,
  output logic             irq_q,
  output logic             fire_done,
  output logic             fire_halt
);

  logic fire_any;
  logic release_req;

  assign fire_done   = gate_evt(done_evt && done_cnt != '0, gen_en,
                                imask[MASK_DONE_BIT]);
  assign fire_halt   = gate_evt(halt_evt, gen_en, imask[MASK_HALT_BIT]);
  assign fire_any    = fire_done | fire_halt;
  assign release_req = stat_wr & wdata[STAT_PEND_BIT] & gen_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else if (soft_rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_wr ? w1c(stat_q, wdata, STAT_CLRMASK) : stat_q)
                | (fire_any ? DW'(1) << STAT_PEND_BIT : '0);
      if (fire_any)         irq_q <= 1'b1;
      else if (release_req) irq_q <= 1'b0;
    end
  end

  a_r3_done_raises: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && done_cnt != '0 && gen_en && imask[MASK_DONE_BIT] && !soft_rst
      |=> irq_q && stat_q[STAT_PEND_BIT]);

  a_r4_halt_raises: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt && gen_en && imask[MASK_HALT_BIT] && !soft_rst
      |=> irq_q && stat_q[STAT_PEND_BIT]);

  a_r5_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en && !irq_q && !soft_rst |=> !irq_q);

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && wdata[STAT_PEND_BIT] && gen_en && !done_evt && !halt_evt
      && !soft_rst |=> !irq_q);

  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fire_any && release_req && !soft_rst |=> irq_q);

endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq
  import i2c_si_pkg::*;
#(
  parameter int AW     = 5,
  parameter int WINDOW = 18,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             xfer_done,
  input  logic [CNT_W-1:0] xfer_bytes,
  input  logic             xfer_halt,
  input  logic             bus_busy,
  output logic             irq
);

  wstrb_t        strb;
  logic          in_window;
  logic          soft_rst;
  logic [DW-1:0] mode_q, imask_q, count_q, direct_q;
  logic [DW-1:0] adrlo_q, adrhi_q, clkdiv_q, stat_q;
  logic          fire_done, fire_halt;

  i2c_si_decode #(.AW(AW), .WINDOW(WINDOW)) u_dec (
    .addr      (reg_addr),
    .wr        (reg_wr),
    .strb      (strb),
    .in_window (in_window)
  );

  i2c_si_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wdata    (reg_wdata),
    .done_evt (xfer_done),
    .done_cnt (xfer_bytes),
    .soft_rst (soft_rst),
    .mode_q   (mode_q),
    .imask_q  (imask_q),
    .count_q  (count_q),
    .direct_q (direct_q),
    .adrlo_q  (adrlo_q),
    .adrhi_q  (adrhi_q),
    .clkdiv_q (clkdiv_q)
  );

  i2c_si_irq #(.CNT_W(CNT_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_wr   (strb.stat),
    .wdata     (reg_wdata),
    .soft_rst  (soft_rst),
    .gen_en    (mode_q[MODE_GEN_BIT]),
    .imask     (imask_q),
    .done_evt  (xfer_done),
    .done_cnt  (xfer_bytes),
    .halt_evt  (xfer_halt),
    .stat_q    (stat_q),
    .irq_q     (irq),
    .fire_done (fire_done),
    .fire_halt (fire_halt)
  );

  always_comb begin
    reg_rdata = '0;
    if (in_window) begin
      case (int'(reg_addr))
        OFF_MODE:   reg_rdata = mode_q;
        OFF_STAT:   reg_rdata = stat_q;
        OFF_XSTAT:  reg_rdata = xstat_code(bus_busy);
        OFF_IMASK:  reg_rdata = imask_q;
        OFF_COUNT:  reg_rdata = count_q;
        OFF_DIRECT: reg_rdata = direct_q;
        OFF_ADRLO:  reg_rdata = adrlo_q;
        OFF_ADRHI:  reg_rdata = adrhi_q;
        OFF_CLKDIV: reg_rdata = clkdiv_q;
        default:    reg_rdata = '0;
      endcase
    end
  end

  a_r7_xstat_live: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == AW'(OFF_XSTAT) |-> reg_rdata[7:6] == 2'b01 &&
      reg_rdata[4] == bus_busy && reg_rdata[3:0] == '0);

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    int'(reg_addr) > OFF_CLKDIV |-> reg_rdata == '0);

  a_r3_no_irq_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq && xfer_done && xfer_bytes == '0 && !xfer_halt && !soft_rst |=> !irq);

endmodule

// File: tb/tb_i2c_stat_irq.sv
module tb_i2c_stat_irq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       xfer_done = 1'b0;
  logic [2:0] xfer_bytes = '0;
  logic       xfer_halt = 1'b0;
  logic       bus_busy = 1'b0;
  logic       irq;
  logic       probe = 1'b0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit       is_irq;
    bit [7:0] exp;
    string    tag;
  } item_t;

  item_t sb[$];

  always #5 clk = ~clk;

  i2c_stat_irq dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .xfer_bytes(xfer_bytes), .xfer_halt(xfer_halt), .bus_busy(bus_busy),
    .irq(irq)
  );

  // monitor: pops the expected item and compares in mid-cycle
  always @(negedge clk) begin
    if (probe) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      act = it.is_irq ? {7'b0, irq} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=0x%02h expected=0x%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    reg_addr = a; probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
    sb.push_back(it);
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic done(input logic [2:0] n);
    xfer_done = 1'b1; xfer_bytes = n;
    @(posedge clk); #1;
    xfer_done = 1'b0; xfer_bytes = '0;
  endtask

  task automatic halt();
    xfer_halt = 1'b1;
    @(posedge clk); #1;
    xfer_halt = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(0, 8'h00, "R1 mode");
    rd(1, 8'h00, "R1 status");
    rd(3, 8'h00, "R1 mask");
    rd(4, 8'h00, "R1 count");
    rd(6, 8'h0F, "R1 direct");
    rd(7, 8'h00, "R1 addr lo");
    rd(9, 8'h00, "R1 clkdiv");
    chk_irq(1'b0, "R1 irq");

    // R2 mode write mask
    wr(0, 8'hFF);
    rd(0, 8'h3D, "R2 mode mask");

    // R3 completion raises, count loaded
    wr(3, 8'h09);
    done(3'd3);
    chk_irq(1'b1, "R3 irq on done");
    rd(1, 8'h02, "R3 status pending");
    rd(4, 8'h03, "R3 count load");

    // R6 clear with enable
    wr(1, 8'h02);
    chk_irq(1'b0, "R6 irq release");
    rd(1, 8'h00, "R6 status cleared");

    // R3 zero count raises nothing
    done(3'd0);
    chk_irq(1'b0, "R3 zero count");
    rd(4, 8'h00, "R3 count zero load");

    // R4 halt raises
    halt();
    chk_irq(1'b1, "R4 irq on halt");
    rd(1, 8'h02, "R4 status pending");

    // R6 clear mask: bits outside 0x0A ignored
    wr(1, 8'hF5);
    rd(1, 8'h02, "R6 mask ignores");
    chk_irq(1'b1, "R6 irq kept");
    wr(1, 8'h0A);
    chk_irq(1'b0, "R6 irq release 0A");

    // R5 mask bit clear
    wr(3, 8'h00);
    done(3'd2);
    chk_irq(1'b0, "R5 masked done");
    rd(1, 8'h00, "R5 status untouched");
    rd(4, 8'h02, "R3 count load 2");

    // R5 global enable clear
    wr(0, 8'h00);
    wr(3, 8'h09);
    halt();
    done(3'd1);
    chk_irq(1'b0, "R5 global disable");

    // R11 event and clear in same cycle
    wr(0, 8'h04);
    reg_addr = 5'd1; reg_wdata = 8'h02; reg_wr = 1'b1; xfer_halt = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; xfer_halt = 1'b0;
    chk_irq(1'b1, "R11 event wins");
    rd(1, 8'h02, "R11 status kept");

    // R6 clear while enable off keeps irq
    wr(0, 8'h00);
    wr(1, 8'h02);
    rd(1, 8'h00, "R6 status clr no enable");
    chk_irq(1'b1, "R6 irq stays without enable");
    wr(0, 8'h04);
    wr(1, 8'h02);
    chk_irq(1'b0, "R6 release after enable");

    // R7 extended status
    bus_busy = 1'b1;
    rd(2, 8'h50, "R7 busy code");
    wr(2, 8'hFF);
    rd(2, 8'h50, "R7 write ignored");
    bus_busy = 1'b0;
    rd(2, 8'h40, "R7 free code");

    // R8 count write mask
    wr(4, 8'hFF);
    rd(4, 8'h77, "R8 count mask");

    // R12 direct control
    wr(6, 8'hF3);
    rd(6, 8'h03, "R12 direct low nibble");

    // R10 reserved offsets
    wr(5'd12, 8'hFF);
    wr(5'd17, 8'hFF);
    wr(5'd21, 8'hFF);
    rd(5'd12, 8'h00, "R10 reserved read");
    rd(5'd21, 8'h00, "R10 outside window read");
    rd(0, 8'h04, "R10 mode untouched");
    rd(4, 8'h77, "R10 count untouched");

    // R9 soft reset
    wr(7, 8'hA5);
    wr(8, 8'h3C);
    wr(9, 8'h55);
    wr(3, 8'h01);
    wr(5, 8'hFE);
    rd(0, 8'h04, "R9 no trigger bit");
    rd(9, 8'h55, "R9 no trigger clkdiv");
    done(3'd1);
    chk_irq(1'b1, "R9 irq before reset");
    wr(5, 8'h01);
    chk_irq(1'b0, "R9 irq dropped");
    rd(0, 8'h00, "R9 mode default");
    rd(1, 8'h00, "R9 status default");
    rd(3, 8'h00, "R9 mask default");
    rd(4, 8'h00, "R9 count default");
    rd(6, 8'h0F, "R9 direct default");
    rd(9, 8'h00, "R9 clkdiv default");
    rd(7, 8'hA5, "R9 addr lo kept");
    rd(8, 8'h3C, "R9 addr hi kept");

    @(posedge clk); #1;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard (all requirements) actual=%0d expected=0", sb.size());
    end
    summary();
    $finish;
  end

endmodule